// File: doc/BRIEF.md
# Prioritized Transmit Request Scheduler

This block keeps the control and status bits of a small set of message transmit slots (three by default). It decides which pending slot is handed next to a bit-level transmitter. The host writes a request bit and a two-bit priority into each slot. The scheduler waits until the bus is idle and picks the most urgent pending slot. It then offers that slot to the transmitter with a start strobe. After that it tracks the outcome the transmitter reports: success, bus error or lost arbitration.

The host can withdraw a request that has not yet been taken by the transmitter. It can also use a global abort-all control, which cancels every pending slot that has not started and blocks new launches until the control is released. A message that has been taken cannot be withdrawn. If that message fails, it stays pending and is launched again. The block also provides per-slot done flags, a global error flag, and two interrupt outputs that are gated by enables.

The sequencer has three states. In ST_IDLE nothing is offered. The transition "launch" (ST_IDLE to ST_OFFER) fires when the bus is idle, abort-all is low and at least one slot is pending; the winning slot number is latched at that point. In ST_OFFER the strobe is high while the latched slot still requests. The transition "take" (ST_OFFER to ST_BUSY) fires when the transmitter accepts. The transition "withdraw" (ST_OFFER to ST_IDLE) fires when the latched slot's request has gone. In ST_BUSY the transition "finish" (ST_BUSY to ST_IDLE) fires on success, error or lost arbitration. After "finish", all slots are compared again.

Top module: `tx_req_sched`

## Requirements
- R1: After reset every status byte, done flag, error flag, interrupt and the start strobe are 0. Slot i's status byte sits at ctrl_stat[8i+7:8i] with this layout: bit 6 aborted, bit 5 lost arbitration, bit 4 bus error, bit 3 request, bits 1:0 priority. Bits 7 and 2 are 0.
- R2: Among slots whose request is set, the scheduler picks the one with the highest priority (3 highest, 0 lowest). When priorities are equal, the higher slot number wins.
- R3: A request does not start anything by itself. A launch happens only in a cycle where bus_idle is 1, abort_all is 0 and a slot is pending, and tx_start rises one clock after that cycle with tx_sel set to the winner. tx_start stays high until tx_accept. It drops in the cycle after the offered slot's request is cleared.
- R4: A write with wr_req=1 sets the request, loads wr_prio, and clears the aborted, lost-arbitration and error bits, all in that one write.
- R5: On tx_success while busy, that slot's request clears and its done flag sets. done_irq is high while any done flag has its done_ie bit set.
- R6: On tx_error while busy, the request stays set, the slot's error bit sets and err_flag sets. err_irq is err_flag AND err_ie.
- R7: On tx_arb_lost while busy, the request stays set and the slot's lost-arbitration bit sets.
- R8: A write to a slot that has not started clears the request when wr_req=0, and the aborted bit stays 0. A write of any kind to the slot in transmission has no effect.
- R9: After an error or lost arbitration, the slot is pending again and is offered again on the next launch.
- R10: A rising edge of abort_all clears the request and sets the aborted bit of every pending slot that has not started. The slot in transmission is not touched. No launch happens while abort_all is high.
- R11: done_ack[i] clears done flag i and err_ack clears err_flag. In the same cycle, a new set wins over the ack.
- R12: If tx_accept arrives in the same cycle as a host clear of the offered slot, the accept wins: the slot is busy and its request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for one slot's control |
| wr_sel | input | IDX_W | Slot number being written |
| wr_req | input | 1 | Request value written |
| wr_prio | input | 2 | Priority value written |
| abort_all | input | 1 | Global abort; the rising edge aborts, high level inhibits launches |
| done_ie | input | NUM_BUF | Per-slot done interrupt enables |
| err_ie | input | 1 | Error interrupt enable |
| done_ack | input | NUM_BUF | Per-slot done flag clear |
| err_ack | input | 1 | Error flag clear |
| bus_idle | input | 1 | Transmitter reports the bus is free to start a frame |
| tx_accept | input | 1 | Transmitter takes the offered slot |
| tx_success | input | 1 | Message sent successfully |
| tx_error | input | 1 | Bus error during the message |
| tx_arb_lost | input | 1 | Message lost arbitration |
| tx_start | output | 1 | Offer strobe, held until accepted |
| tx_sel | output | IDX_W | Offered or active slot number |
| ctrl_stat | output | 8*NUM_BUF | Status bytes of all slots |
| done_flag | output | NUM_BUF | Per-slot transmit-done flags |
| err_flag | output | 1 | Global message-error flag |
| done_irq | output | 1 | Gated done interrupt |
| err_irq | output | 1 | Gated error interrupt |

## Verification
The hard case is a host clear of the offered slot landing in the same clock as the transmitter's accept. The bench drives wr_en (clearing the request) and tx_accept at the same negative edge while the slot is being offered. It then checks that the strobe has dropped because the block is busy, not because the offer was withdrawn, and that the status byte still shows the request. A second collision is tested too: abort_all rises while another slot is in transmission. The bench checks that only the untouched pending slots show the aborted bit, and that the busy slot still completes.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;

    localparam int PRIO_W = 2;

    // status byte bit positions
    localparam int BIT_ABT  = 6;
    localparam int BIT_LOST = 5;
    localparam int BIT_ERR  = 4;
    localparam int BIT_REQ  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_BUSY  = 2'd2
    } sched_state_t;

endpackage

// File: rtl/tx_prio_pick.sv
module tx_prio_pick
    import tx_sched_pkg::*;
#(
    parameter int NUM_BUF = 3,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic [NUM_BUF-1:0]        req,
    input  logic [NUM_BUF*PRIO_W-1:0] prio,
    output logic                      win_valid,
    output logic [IDX_W-1:0]          win_idx
);

    logic [PRIO_W-1:0] best;

    // Ascending scan with >= so a later slot wins on equal priority.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best      = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (req[i] && (!win_valid || prio[i*PRIO_W +: PRIO_W] >= best)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best      = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/tx_slot_ctrl.sv
module tx_slot_ctrl
    import tx_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              wr_req,
    input  logic [PRIO_W-1:0] wr_prio,
    input  logic              abort_hit,
    input  logic              ev_ok,
    input  logic              ev_err,
    input  logic              ev_lost,
    input  logic              done_ack,
    output logic              req_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic              abt_o,
    output logic              lost_o,
    output logic              err_o,
    output logic              done_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            prio_o <= '0;
            abt_o  <= 1'b0;
            lost_o <= 1'b0;
            err_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            if (wr_hit) begin
                req_o  <= wr_req;
                prio_o <= wr_prio;
                if (wr_req) begin
                    abt_o  <= 1'b0;
                    lost_o <= 1'b0;
                    err_o  <= 1'b0;
                end
            end
            if (abort_hit) begin
                req_o <= 1'b0;
                abt_o <= 1'b1;
            end
            if (ev_ok)   req_o  <= 1'b0;
            if (ev_err)  err_o  <= 1'b1;
            if (ev_lost) lost_o <= 1'b1;
            if (done_ack) done_o <= 1'b0;
            if (ev_ok)    done_o <= 1'b1;
        end
    end

    // R5
    ok_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ok |=> (!req_o && done_o));

    // R6
    err_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> (req_o && err_o));

    // R7
    lost_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lost |=> (req_o && lost_o));

    // R4
    req_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_req && !abort_hit) |=> (req_o && !abt_o && !lost_o && !err_o));

endmodule

// File: rtl/tx_sched_fsm.sv
module tx_sched_fsm
    import tx_sched_pkg::*;
#(
    parameter int NUM_BUF = 3,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_idle,
    input  logic             inhibit,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             cur_req,
    input  logic             accept,
    input  logic             success,
    input  logic             error,
    input  logic             lost,
    output logic [IDX_W-1:0] cur_idx,
    output logic             tx_start,
    output logic             busy,
    output logic             taking
);

    sched_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && nxt == ST_OFFER) cur_idx <= win_idx;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (bus_idle && !inhibit && win_valid) nxt = ST_OFFER;
            ST_OFFER: begin
                if (cur_req && accept) nxt = ST_BUSY;
                else if (!cur_req)     nxt = ST_IDLE;
            end
            ST_BUSY:  if (success || error || lost) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_start = 1'b0;
        busy     = 1'b0;
        taking   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_OFFER: begin
                tx_start = cur_req;
                taking   = cur_req && accept;
            end
            ST_BUSY:  busy = 1'b1;
            default:  ;
        endcase
    end

    // R3
    no_launch_when_bus_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !bus_idle) |=> !tx_start);

endmodule

// File: rtl/tx_req_sched.sv
module tx_req_sched
    import tx_sched_pkg::*;
#(
    parameter int NUM_BUF = 3,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_sel,
    input  logic                 wr_req,
    input  logic [PRIO_W-1:0]    wr_prio,
    input  logic                 abort_all,
    input  logic [NUM_BUF-1:0]   done_ie,
    input  logic                 err_ie,
    input  logic [NUM_BUF-1:0]   done_ack,
    input  logic                 err_ack,
    input  logic                 bus_idle,
    input  logic                 tx_accept,
    input  logic                 tx_success,
    input  logic                 tx_error,
    input  logic                 tx_arb_lost,
    output logic                 tx_start,
    output logic [IDX_W-1:0]     tx_sel,
    output logic [8*NUM_BUF-1:0] ctrl_stat,
    output logic [NUM_BUF-1:0]   done_flag,
    output logic                 err_flag,
    output logic                 done_irq,
    output logic                 err_irq
);

    logic [NUM_BUF-1:0]        req_v, abt_v, lost_v, err_v, cur_hit, started;
    logic [NUM_BUF*PRIO_W-1:0] prio_v;
    logic                      win_valid, cur_req, busy, taking, abort_q, abort_edge;
    logic [IDX_W-1:0]          win_idx, cur_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= abort_all;
    end
    assign abort_edge = abort_all && !abort_q;

    tx_prio_pick #(.NUM_BUF(NUM_BUF)) u_pick (
        .req       (req_v),
        .prio      (prio_v),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    tx_sched_fsm #(.NUM_BUF(NUM_BUF)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_idle  (bus_idle),
        .inhibit   (abort_all),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .cur_req   (cur_req),
        .accept    (tx_accept),
        .success   (tx_success),
        .error     (tx_error),
        .lost      (tx_arb_lost),
        .cur_idx   (cur_idx),
        .tx_start  (tx_start),
        .busy      (busy),
        .taking    (taking)
    );

    assign cur_req = |(req_v & cur_hit);
    assign tx_sel  = cur_idx;

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
        logic wr_hit_i, abort_hit_i, ok_i, err_i, lost_i;

        assign cur_hit[i]  = (cur_idx == IDX_W'(i));
        assign started[i]  = cur_hit[i] && (busy || taking);
        assign wr_hit_i    = wr_en && (wr_sel == IDX_W'(i)) && !started[i];
        assign abort_hit_i = abort_edge && req_v[i] && !started[i];
        assign ok_i        = busy && cur_hit[i] && tx_success;
        assign err_i       = busy && cur_hit[i] && !tx_success && tx_error;
        assign lost_i      = busy && cur_hit[i] && !tx_success && !tx_error && tx_arb_lost;

        tx_slot_ctrl u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (wr_hit_i),
            .wr_req    (wr_req),
            .wr_prio   (wr_prio),
            .abort_hit (abort_hit_i),
            .ev_ok     (ok_i),
            .ev_err    (err_i),
            .ev_lost   (lost_i),
            .done_ack  (done_ack[i]),
            .req_o     (req_v[i]),
            .prio_o    (prio_v[i*PRIO_W +: PRIO_W]),
            .abt_o     (abt_v[i]),
            .lost_o    (lost_v[i]),
            .err_o     (err_v[i]),
            .done_o    (done_flag[i])
        );

        assign ctrl_stat[8*i +: 8] = {1'b0, abt_v[i], lost_v[i], err_v[i],
                                      req_v[i], 1'b0, prio_v[i*PRIO_W +: PRIO_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_flag <= 1'b0;
        else if (busy && !tx_success && tx_error) err_flag <= 1'b1;
        else if (err_ack) err_flag <= 1'b0;
    end

    assign done_irq = |(done_flag & done_ie);
    assign err_irq  = err_flag && err_ie;

    // R8
    busy_slot_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cur_req);

    // R10
    abort_stops_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_edge |=> !tx_start);

endmodule

// File: tb/tx_req_sched_tb.sv
module tx_req_sched_tb;

    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic          wr_req = 1'b0;
    logic [1:0]    wr_prio = '0;
    logic          abort_all = 1'b0;
    logic [NB-1:0] done_ie = '1;
    logic          err_ie = 1'b1;
    logic [NB-1:0] done_ack = '0;
    logic          err_ack = 1'b0;
    logic          bus_idle = 1'b0;
    logic          tx_accept = 1'b0, tx_success = 1'b0, tx_error = 1'b0, tx_arb_lost = 1'b0;
    logic          tx_start;
    logic [1:0]    tx_sel;
    logic [8*NB-1:0] ctrl_stat;
    logic [NB-1:0] done_flag;
    logic          err_flag, done_irq, err_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tx_req_sched #(.NUM_BUF(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_req(wr_req),
        .wr_prio(wr_prio), .abort_all(abort_all), .done_ie(done_ie), .err_ie(err_ie),
        .done_ack(done_ack), .err_ack(err_ack), .bus_idle(bus_idle),
        .tx_accept(tx_accept), .tx_success(tx_success), .tx_error(tx_error),
        .tx_arb_lost(tx_arb_lost), .tx_start(tx_start), .tx_sel(tx_sel),
        .ctrl_stat(ctrl_stat), .done_flag(done_flag), .err_flag(err_flag),
        .done_irq(done_irq), .err_irq(err_irq)
    );

    // {prio2, prio1, prio0, request mask, expected winner}
    localparam logic [10:0] PICK_TAB [8] = '{
        {2'd0, 2'd0, 2'd2, 3'b001, 2'd0},
        {2'd0, 2'd0, 2'd0, 3'b111, 2'd2},
        {2'd1, 2'd2, 2'd3, 3'b111, 2'd0},
        {2'd0, 2'd2, 2'd2, 3'b011, 2'd1},
        {2'd3, 2'd0, 2'd3, 3'b101, 2'd2},
        {2'd3, 2'd3, 2'd1, 3'b111, 2'd2},
        {2'd0, 2'd0, 2'd3, 3'b011, 2'd0},
        {2'd1, 2'd2, 2'd0, 3'b110, 2'd1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input int b, input logic rq, input logic [1:0] pr);
        wr_en = 1'b1; wr_sel = 2'(b); wr_req = rq; wr_prio = pr;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_accept();
        tx_accept = 1'b1; tick(); tx_accept = 1'b0;
    endtask

    function automatic int sbyte(input int b);
        return int'(ctrl_stat[8*b +: 8]);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 status bytes", int'(ctrl_stat), 0);
        chk("R1 tx_start", int'(tx_start), 0);
        chk("R1 flags+irqs", int'({done_flag, err_flag, done_irq, err_irq}), 0);

        // R2 priority table
        for (int k = 0; k < 8; k++) begin
            bus_idle = 1'b0;
            for (int b = 0; b < NB; b++)
                host_write(b, PICK_TAB[k][2+b], PICK_TAB[k][5+2*b +: 2]);
            bus_idle = 1'b1;
            tick();
            chk("R2 start", int'(tx_start), 1);
            chk("R2 winner", int'(tx_sel), int'(PICK_TAB[k][1:0]));
            bus_idle = 1'b0;
            for (int b = 0; b < NB; b++) host_write(b, 1'b0, 2'd0);
            tick();
        end

        // R3 request alone does not launch
        host_write(1, 1'b1, 2'd2);
        chk("R4 req+prio in one write", sbyte(1), 8'h0A);
        tick(); tick(); tick();
        chk("R3 no start without idle bus", int'(tx_start), 0);
        bus_idle = 1'b1;
        tick();
        chk("R3 offer after idle", int'({tx_start, tx_sel}), 5);
        pulse_accept();
        host_write(1, 1'b0, 2'd0);
        chk("R8 write to busy slot ignored", sbyte(1), 8'h0A);
        tx_error = 1'b1; tick(); tx_error = 1'b0;
        chk("R6 error status", sbyte(1), 8'h1A);
        chk("R6 err flag/irq", int'({err_flag, err_irq}), 3);
        tick();
        chk("R9 retry offered", int'({tx_start, tx_sel}), 5);
        pulse_accept();
        tx_arb_lost = 1'b1; tick(); tx_arb_lost = 1'b0;
        chk("R7 lost status", sbyte(1), 8'h3A);
        host_write(1, 1'b1, 2'd2);
        chk("R4 flags cleared by request write", sbyte(1), 8'h0A);
        err_ack = 1'b1; tick(); err_ack = 1'b0;
        chk("R11 err ack", int'({err_flag, err_irq}), 0);
        chk("R9 retry after lost", int'({tx_start, tx_sel}), 5);
        pulse_accept();
        tx_success = 1'b1; tick(); tx_success = 1'b0;
        chk("R5 success status", sbyte(1), 8'h02);
        chk("R5 done flag/irq", int'({done_flag, done_irq}), 4'b0101);
        done_ack = 3'b010; tick(); done_ack = '0;
        chk("R11 done ack", int'({done_flag, done_irq}), 0);

        // R12 accept and host clear in the same cycle
        host_write(0, 1'b1, 2'd1);
        tick();
        chk("R12 offer slot0", int'({tx_start, tx_sel}), 4);
        tx_accept = 1'b1;
        wr_en = 1'b1; wr_sel = 2'd0; wr_req = 1'b0; wr_prio = 2'd1;
        tick();
        tx_accept = 1'b0; wr_en = 1'b0;
        chk("R12 request kept", sbyte(0), 8'h09);
        chk("R12 busy, no strobe", int'(tx_start), 0);
        tx_success = 1'b1; tick(); tx_success = 1'b0;
        chk("R5 slot0 done", int'({sbyte(0), done_flag}), {8'h01, 3'b001});
        done_ack = 3'b001; tick(); done_ack = '0;

        // R8 host clear of pending slot
        bus_idle = 1'b0;
        host_write(2, 1'b1, 2'd3);
        host_write(2, 1'b0, 2'd3);
        chk("R8 clear pending, no abort bit", sbyte(2), 8'h03);

        // R10 abort-all with one slot in transmission
        host_write(0, 1'b1, 2'd0);
        host_write(1, 1'b1, 2'd1);
        host_write(2, 1'b1, 2'd3);
        bus_idle = 1'b1;
        tick();
        chk("R2 highest wins", int'({tx_start, tx_sel}), 6);
        pulse_accept();
        bus_idle = 1'b0;
        abort_all = 1'b1;
        tick();
        chk("R10 slot0 aborted", sbyte(0), 8'h40);
        chk("R10 slot1 aborted", sbyte(1), 8'h41);
        chk("R10 busy slot untouched", sbyte(2), 8'h0B);
        tx_success = 1'b1; tick(); tx_success = 1'b0;
        chk("R5 busy slot completes", sbyte(2), 8'h03);
        host_write(0, 1'b1, 2'd0);
        chk("R4 abort bit cleared", sbyte(0), 8'h08);
        bus_idle = 1'b1;
        tick(); tick();
        chk("R10 inhibited while high", int'(tx_start), 0);
        abort_all = 1'b0;
        tick();
        chk("R10 launch after release", int'({tx_start, tx_sel}), 4);
        host_write(0, 1'b0, 2'd0);
        chk("R3 offer withdrawn", int'(tx_start), 0);
        chk("R8 withdrawn request", sbyte(0), 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule